// File: doc/BRIEF.md
# Auto-Width SPI Slave Front End

This block turns host SPI traffic into word accesses on a simple internal bus. Every transfer starts when CSn goes low. It is a one-byte opcode followed by a 16-bit word address, both sent MSB first. Any number of 16-bit data words can follow. The address advances by one after each word. Opcode `8'h02` writes and opcode `8'h03` reads. Every other opcode is consumed silently.

The SPI pins are oversampled by the system clock (nominally 80 MHz). All frame logic runs in that domain, so the downstream bus sees ordinary single-cycle strobes.

After reset the port works one bit per clock on MOSI. During the first two SCLK rising edges of a command, the port watches MISO, which the board pulls up. If the host pulls it low on both edges, the port switches to two-bit transfers and stays in that mode until the next reset. In that mode every edge carries a bit pair: the odd (higher) bit on MISO and the even (lower) bit on MOSI, in both directions. The two detection edges already count as the first four opcode bits.

Top module: `spi_autowidth_slave`

## Requirements
- R1: After reset the port is in single-bit mode: it takes one bit per SCLK rising edge from MOSI, MSB first, and a MISO left undriven (pulled high) keeps it there.
- R2: In single mode, if MISO is low on both the first and the second SCLK rising edge of a command, the port enters dual mode. The bits on those two edges are then read as the opcode bit pairs 7/6 and 5/4.
- R3: Dual mode persists through any later CSn cycles and commands, including commands whose first MISO bits are high, until reset.
- R4: A command where MISO is low on only one of its first two rising edges leaves the port in single mode.
- R5: Frame format: opcode `8'h02` is a write, `8'h03` is a read, then a 16-bit address and 16-bit words, all MSB first. Any other opcode produces no bus strobe and no pad drive until CSn rises.
- R6: Input bits are sampled on SCLK rising edges and output bits change after falling edges. The MSB of the first read word is on the pads before the first rising edge of the data phase.
- R7: In dual mode every SCLK edge carries two bits: the odd bit on MISO and the even bit below it on MOSI, for commands, addresses, write data and read data. MOSI is driven only in dual mode.
- R8: Each complete write word gives a one-clock `bus_we` pulse carrying the frame address and the word. The address then increments, so bursts of any length fill consecutive addresses.
- R9: A read issues a one-clock `bus_re` at the current address once the address is complete, and again after each read word. `bus_rdata` is captured one clock after `bus_re`. Consecutive words come from consecutive addresses.
- R10: The pad output enables are high only while CSn is low and the frame is in its read data phase. They are never high during the opcode or the address, and all are low after reset.
- R11: Raising CSn abandons a partial frame: a partial word causes no write, and the next command starts again at the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset; also returns the width to single |
| sclk_i | input | 1 | SPI clock from the host, idle low |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output value (dual read only) |
| mosi_oe | output | 1 | MOSI pad output enable |
| miso_i | input | 1 | MISO pad input (pulled up on the board) |
| miso_o | output | 1 | MISO pad output value |
| miso_oe | output | 1 | MISO pad output enable |
| bus_addr | output | 16 | Word address of the current access |
| bus_wdata | output | 16 | Write data, valid with bus_we |
| bus_we | output | 1 | One-clock write strobe |
| bus_re | output | 1 | One-clock read strobe |
| bus_rdata | input | 16 | Read data, sampled one clock after bus_re |

## Verification
The bench goes after width detection in three forms:
- Undriven MISO, where a design that ignored the pull-up would wrongly go dual.
- A single low edge, where a design checking only the first edge would switch and garble every later word.
- A true dual entry, where a design that discarded the two detection edges would decode a shifted opcode and never strobe the bus.

After dual entry it issues an unknown command with high MISO bits and then a dual burst, which exposes a port that re-detects on each CSn cycle.

Multi-word bursts in both widths catch a missing or doubled address increment and a read word fetched too late for its first falling edge. A frame cut short mid-word shows whether a partial word leaks out as a write.

// File: rtl/spi_autowidth_slave.sv
module spi_autowidth_slave #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OPW = 8,
  parameter logic [OPW-1:0] OP_WR = 8'h02,
  parameter logic [OPW-1:0] OP_RD = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata
);
  localparam int SW = (AW > DW) ? AW : DW;
  localparam int CW = $clog2(SW) + 1;

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_WDATA, PH_RDATA, PH_SKIP} ph_t;

  logic [1:0] sclk_m, csn_m, mosi_m, miso_m;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 2'b00;
      csn_m  <= 2'b11;
      mosi_m <= 2'b00;
      miso_m <= 2'b11;
      sclk_d <= 1'b0;
    end else begin
      sclk_m <= {sclk_m[0], sclk_i};
      csn_m  <= {csn_m[0], csn_i};
      mosi_m <= {mosi_m[0], mosi_i};
      miso_m <= {miso_m[0], miso_i};
      sclk_d <= sclk_m[1];
    end
  end

  wire sclk_s = sclk_m[1];
  wire mosi_s = mosi_m[1];
  wire miso_s = miso_m[1];
  wire active = ~csn_m[1];
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;

  ph_t           ph;
  logic [CW-1:0] bcnt;
  logic [SW-1:0] rx_sh;
  logic [DW-1:0] tx_sh, wdata_q;
  logic [AW-1:0] addr_q;
  logic          dual_q, det0_q, is_rd_q, drv_q;
  logic          we_q, re_q, ld_q, miso_q, mosi_q;

  wire [SW-1:0] rx_next  = dual_q ? {rx_sh[SW-3:0], miso_s, mosi_s} : {rx_sh[SW-2:0], mosi_s};
  wire [CW-1:0] cnt_next = bcnt + (dual_q ? CW'(2) : CW'(1));
  wire [CW-1:0] flen     = (ph == PH_OP) ? CW'(OPW) : (ph == PH_ADDR) ? CW'(AW) : CW'(DW);
  wire switch_now = !dual_q && (ph == PH_OP) && (bcnt == CW'(1)) && det0_q && !miso_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_OP;
      bcnt    <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      dual_q  <= 1'b0;
      det0_q  <= 1'b0;
      is_rd_q <= 1'b0;
      drv_q   <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      ld_q    <= 1'b0;
      miso_q  <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      ld_q <= re_q;
      if (we_q || re_q) addr_q <= addr_q + AW'(1);
      if (ld_q) tx_sh <= bus_rdata;

      if (!active) begin
        ph     <= PH_OP;
        bcnt   <= '0;
        det0_q <= 1'b0;
        drv_q  <= 1'b0;
      end else begin
        if (rise) begin
          case (ph)
            PH_SKIP: ;
            PH_RDATA: begin
              if (cnt_next == CW'(DW)) begin
                bcnt <= '0;
                re_q <= 1'b1;
              end else begin
                bcnt <= cnt_next;
              end
            end
            default: begin
              if (ph == PH_OP && bcnt == '0) det0_q <= ~miso_s;
              if (switch_now) begin
                dual_q <= 1'b1;
                rx_sh  <= {{(SW-4){1'b0}}, 1'b0, rx_sh[0], 1'b0, mosi_s};
                bcnt   <= CW'(4);
              end else begin
                rx_sh <= rx_next;
                if (cnt_next == flen) begin
                  bcnt <= '0;
                  case (ph)
                    PH_OP: begin
                      if (rx_next[OPW-1:0] == OP_WR) begin
                        ph <= PH_ADDR;
                        is_rd_q <= 1'b0;
                      end else if (rx_next[OPW-1:0] == OP_RD) begin
                        ph <= PH_ADDR;
                        is_rd_q <= 1'b1;
                      end else begin
                        ph <= PH_SKIP;
                      end
                    end
                    PH_ADDR: begin
                      addr_q <= rx_next[AW-1:0];
                      ph     <= is_rd_q ? PH_RDATA : PH_WDATA;
                      re_q   <= is_rd_q;
                    end
                    PH_WDATA: begin
                      we_q    <= 1'b1;
                      wdata_q <= rx_next[DW-1:0];
                    end
                    default: ;
                  endcase
                end else begin
                  bcnt <= cnt_next;
                end
              end
            end
          endcase
        end
        if (fall && ph == PH_RDATA) begin
          miso_q <= tx_sh[DW-1];
          mosi_q <= tx_sh[DW-2];
          drv_q  <= 1'b1;
          tx_sh  <= dual_q ? (tx_sh << 2) : (tx_sh << 1);
        end
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_we    = we_q;
  assign bus_re    = re_q;
  assign miso_o    = miso_q;
  assign mosi_o    = mosi_q;
  assign miso_oe   = drv_q & ~csn_i;
  assign mosi_oe   = drv_q & dual_q & ~csn_i;

  p_dual_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual_q) |-> dual_q);

  p_switch_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dual_q) |-> ($past(ph) == PH_OP && $past(bcnt) == CW'(1)));

  p_no_drive_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OP || ph == PH_ADDR) |-> (!miso_oe && !mosi_oe));

  p_mosi_dual_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mosi_oe |-> dual_q);

  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SKIP) |-> (!bus_we && !bus_re));

  p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (bus_addr == $past(bus_addr) + AW'(1)));

  p_re_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re);
endmodule

// File: tb/spi_autowidth_slave_tb_top.sv
module spi_autowidth_slave_tb_top;
  localparam int CLK_PERIOD = 12;
  localparam int HALF = 8 * CLK_PERIOD;
  localparam logic [31:0] VEC [0:5] = '{
    32'h0001_1357, 32'h0002_FFFF, 32'h0003_0000,
    32'h00FE_8001, 32'h0007_7FFE, 32'h0011_C3A5};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1;
  logic h_mosi = 1'b0, h_mosi_oe = 1'b0, h_miso = 1'b0, h_miso_oe = 1'b0;
  logic host_dual = 1'b0, host_cmd = 1'b0, done = 1'b0;
  int   force_low = 0;
  logic mosi_o, mosi_oe, miso_o, miso_oe, bus_we, bus_re;
  logic [15:0] bus_addr, bus_wdata, rd_q;
  logic [15:0] mem [0:255];
  logic [15:0] wa_log [0:63];
  logic [15:0] wd_log [0:63];
  logic [15:0] wbuf [0:7];
  logic [15:0] rbuf [0:7];
  int n_we = 0, n_re = 0, oe_bad = 0, mosi_bad = 0;
  int n_chk = 0, n_bad = 0;

  wire mosi_ln = mosi_oe ? mosi_o : (h_mosi_oe ? h_mosi : 1'b0);
  wire miso_ln = miso_oe ? miso_o : (h_miso_oe ? h_miso : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_autowidth_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn),
    .mosi_i(mosi_ln), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_ln), .miso_o(miso_o), .miso_oe(miso_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(rd_q));

  always @(posedge clk) begin
    if (bus_we) begin
      mem[bus_addr[7:0]] <= bus_wdata;
      wa_log[n_we % 64] <= bus_addr;
      wd_log[n_we % 64] <= bus_wdata;
      n_we <= n_we + 1;
    end
    if (bus_re) begin
      rd_q <= mem[bus_addr[7:0]];
      n_re <= n_re + 1;
    end
    if (host_cmd && (miso_oe || mosi_oe)) oe_bad <= oe_bad + 1;
    if (!host_dual && mosi_oe) mosi_bad <= mosi_bad + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i -= (host_dual ? 2 : 1)) begin
      if (host_dual) begin
        h_miso_oe = 1'b1; h_miso = v[i];
        h_mosi_oe = 1'b1; h_mosi = v[i-1];
      end else begin
        h_mosi_oe = 1'b1; h_mosi = v[i];
        h_miso_oe = (force_low > 0); h_miso = 1'b0;
        if (force_low > 0) force_low--;
      end
      #HALF sclk = 1'b1;
      #HALF sclk = 1'b0;
    end
  endtask

  task automatic recv(output logic [15:0] v);
    h_miso_oe = 1'b0; h_mosi_oe = 1'b0; v = '0;
    for (int i = 15; i >= 0; i -= (host_dual ? 2 : 1)) begin
      #HALF;
      if (host_dual) begin v[i] = miso_ln; v[i-1] = mosi_ln; end
      else v[i] = miso_ln;
      sclk = 1'b1;
      #HALF sclk = 1'b0;
    end
  endtask

  task automatic cmd_head(input logic [7:0] op, input logic [15:0] addr);
    csn = 1'b0; host_cmd = 1'b1;
    #HALF;
    send({8'h00, op}, 8);
    send(addr, 16);
    host_cmd = 1'b0;
  endtask

  task automatic cmd_end();
    h_miso_oe = 1'b0; h_mosi_oe = 1'b0;
    #HALF csn = 1'b1;
    #(HALF * 2);
  endtask

  task automatic do_write(input logic [15:0] addr, input int n);
    cmd_head(8'h02, addr);
    for (int k = 0; k < n; k++) send(wbuf[k], 16);
    cmd_end();
  endtask

  task automatic do_read(input logic [15:0] addr, input int n);
    cmd_head(8'h03, addr);
    for (int k = 0; k < n; k++) recv(rbuf[k]);
    cmd_end();
  endtask

  task automatic write_and_verify(input string req, input logic [15:0] addr, input int n);
    int base;
    base = n_we;
    do_write(addr, n);
    check({req, " write count"}, n_we - base, n);
    for (int k = 0; k < n; k++) begin
      check({req, " write addr"}, {16'h0, wa_log[(base + k) % 64]}, {16'h0, addr + 16'(k)});
      check({req, " write data"}, {16'h0, wd_log[(base + k) % 64]}, {16'h0, wbuf[k]});
    end
    do_read(addr, n);
    for (int k = 0; k < n; k++)
      check({req, " read data"}, {16'h0, rbuf[k]}, {16'h0, wbuf[k]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int we0, re0;
    #(CLK_PERIOD * 10 + 3);
    rst_n = 1'b1;
    #(CLK_PERIOD * 4);
    check("R10 idle after reset", {28'h0, miso_oe, mosi_oe, bus_we, bus_re}, 32'h0);

    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][15:0];
      write_and_verify("R1 R6 R8 R9 table", VEC[v][31:16], 1);
    end

    force_low = 1;
    wbuf[0] = 16'h1234;
    write_and_verify("R4 one low edge", 16'h0020, 1);

    we0 = n_we; re0 = n_re;
    cmd_head(8'hA5, 16'h0021);
    send(16'hFFFF, 16);
    send(16'h0000, 16);
    cmd_end();
    check("R5 unknown opcode no strobe", n_we - we0 + n_re - re0, 0);

    we0 = n_we;
    cmd_head(8'h02, 16'h0030);
    send(16'h00EF, 8);
    cmd_end();
    check("R11 partial word no write", n_we - we0, 0);
    wbuf[0] = 16'h4321;
    write_and_verify("R11 fresh frame", 16'h0030, 1);

    wbuf[0] = 16'hA001; wbuf[1] = 16'h5002; wbuf[2] = 16'h0FF3; wbuf[3] = 16'hF004;
    write_and_verify("R8 R9 single burst", 16'h0040, 4);

    host_dual = 1'b1;
    wbuf[0] = 16'h9C3E; wbuf[1] = 16'h0F0F;
    write_and_verify("R2 R7 dual entry", 16'h0050, 2);

    cmd_head(8'hF0, 16'hFFFF);
    cmd_end();
    wbuf[0] = 16'h5AA5; wbuf[1] = 16'hC001; wbuf[2] = 16'h3FFC;
    write_and_verify("R3 R7 dual sticky", 16'h0060, 3);

    do_read(16'h0041, 3);
    check("R3 R9 dual burst read w0", {16'h0, rbuf[0]}, 32'h5002);
    check("R3 R9 dual burst read w1", {16'h0, rbuf[1]}, 32'h0FF3);
    check("R3 R9 dual burst read w2", {16'h0, rbuf[2]}, 32'hF004);

    check("R10 no drive in opcode or address", oe_bad, 0);
    check("R7 no MOSI drive in single mode", mosi_bad, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule